// File: doc/BRIEF.md
# Processor Subsystem Power Sequencer

This block is a hardware state machine that walks a processor subsystem through a fixed power-up order and a fixed shutdown order, so software does not have to poke each control in turn. It drives the subsystem's core clock enable, power headswitch, LDO bypass, IO clamp, memory retention and sleep enables (with one enable per L2 data bank), core reset, bus reset and core stop.

A single-cycle `pwr_up_i` pulse starts power-up when the subsystem is off. A `pwr_down_i` pulse starts shutdown when it is on. Consecutive steps are spaced by `STEP_GAP` clock cycles. The step after the headswitch turns on waits `SETTLE_CYC` cycles so the rail can settle. The L2 data banks are switched on one at a time, highest index first, to limit inrush current. `busy_o` covers each sequence and `done_o` pulses once when it ends.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, the IO clamp, core reset, bus reset and core stop are high, and every other control output, `busy_o` and `done_o` are low.
- R2: A power-up command accepted at a clock edge raises core reset, bus reset and core stop at that same edge, before any power or memory control changes.
- R3: `STEP_GAP` cycles after power-up starts, the headswitch and LDO bypass rise together. Memory controls stay off for a further `SETTLE_CYC` cycles, and no memory enable is ever high while the headswitch is off.
- R4: After the settle wait, retention, L2 tag, trace memory and L2 data standby rise in one step. The L2 data bank enables then rise one per step, from bit `NUM_BANKS-1` down to bit 0, `STEP_GAP` cycles apart.
- R5: After bank 0, these steps follow, each `STEP_GAP` cycles after the last: IO clamp falls, then core reset falls, then the core clock enable rises, then core stop falls. Bus reset stays high throughout.
- R6: Shutdown applies these steps `STEP_GAP` cycles apart, the first at the accepting edge: core clock off, then IO clamp on, then all memory enables (including every bank) off, then core reset and bus reset on, then headswitch off. Core stop and LDO bypass are left as they were.
- R7: `busy_o` is high from the edge that accepts a command until the edge that applies the sequence's last step. `done_o` is high for exactly the one cycle after that edge.
- R8: Commands are ignored while `busy_o` is high. A power-up command is ignored when the subsystem is already on, and a shutdown command is ignored when it is already off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Power-up command |
| pwr_down_i | input | 1 | Shutdown command |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| core_clk_en_o | output | 1 | Core clock enable |
| hs_en_o | output | 1 | Power headswitch enable |
| ldo_byp_o | output | 1 | LDO bypass |
| io_clamp_o | output | 1 | IO clamp, high means clamped |
| mem_ret_en_o | output | 1 | Memory retention enable |
| l2_tag_en_o | output | 1 | L2 tag memory enable |
| trace_mem_en_o | output | 1 | Trace buffer memory enable |
| l2_stby_o | output | 1 | L2 data standby enable |
| l2_bank_en_o | output | NUM_BANKS | Per-bank L2 data enable |
| core_rst_o | output | 1 | Core reset, high means in reset |
| bus_rst_o | output | 1 | Bus reset enable |
| core_halt_o | output | 1 | Core stop, high means stopped |

## Verification
The assertions check the following on every cycle:
- no memory enable is high without the headswitch;
- bank enables rise one at a time and in descending order;
- the core clock only runs when the clamp is off, core reset is off, bus reset is on and power is present;
- `done_o` is a lone pulse outside `busy_o`;
- the step index never jumps backwards or restarts mid-sequence.

The exact step spacing, the length of the settle wait, and which commands are ignored in each state are shown only by the bench's scenarios. Those scenarios compare every control output with a cycle-by-cycle schedule derived from the requirements.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_UP,
    PH_ON,
    PH_DOWN
  } phase_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_HOLD_RST,
    ACT_PWR_ON,
    ACT_MEM_BASE,
    ACT_BANK,
    ACT_UNCLAMP,
    ACT_CORE_REL,
    ACT_CLK_ON,
    ACT_RUN,
    ACT_CLK_OFF,
    ACT_CLAMP,
    ACT_MEM_OFF,
    ACT_RST,
    ACT_PWR_OFF
  } act_e;

  localparam int DN_STEPS = 5;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int STEP_GAP   = 4,
  parameter int SETTLE_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic expired_o
);
  localparam int MAX_W = (STEP_GAP > SETTLE_CYC) ? STEP_GAP : SETTLE_CYC;
  localparam int CNT_W = (MAX_W > 1) ? $clog2(MAX_W + 1) : 1;
  localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(STEP_GAP - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= long_i ? SETTLE_LD : GAP_LD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // a new wait is only armed once the previous one has run out
  p_load_when_due_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> expired_o);

  // a counting wait shrinks by exactly one per cycle
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int UP_STEPS = 7 + NUM_BANKS,
  localparam int IDX_W    = $clog2(UP_STEPS),
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_req_i,
  input  logic             down_req_i,
  input  logic             expired_i,
  output act_e             act_o,
  output logic [SEL_W-1:0] bank_sel_o,
  output logic             load_o,
  output logic             long_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int BANK_LO = 3;
  localparam int BANK_HI = 2 + NUM_BANKS;

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q;
  logic             fire, last, go_up;
  act_e             act;

  function automatic act_e up_act(input logic [IDX_W-1:0] i);
    int k;
    k = int'(i);
    if (k == 0)                  return ACT_HOLD_RST;
    else if (k == 1)             return ACT_PWR_ON;
    else if (k == 2)             return ACT_MEM_BASE;
    else if (k <= BANK_HI)       return ACT_BANK;
    else if (k == BANK_HI + 1)   return ACT_UNCLAMP;
    else if (k == BANK_HI + 2)   return ACT_CORE_REL;
    else if (k == BANK_HI + 3)   return ACT_CLK_ON;
    else                         return ACT_RUN;
  endfunction

  function automatic act_e dn_act(input logic [IDX_W-1:0] i);
    case (int'(i))
      0:       return ACT_CLK_OFF;
      1:       return ACT_CLAMP;
      2:       return ACT_MEM_OFF;
      3:       return ACT_RST;
      default: return ACT_PWR_OFF;
    endcase
  endfunction

  always_comb begin
    fire    = 1'b0;
    idx_d   = idx_q;
    phase_d = phase_q;
    go_up   = (phase_q == PH_UP);
    unique case (phase_q)
      PH_OFF: if (up_req_i) begin
        fire = 1'b1; idx_d = '0; go_up = 1'b1; phase_d = PH_UP;
      end
      PH_ON: if (down_req_i) begin
        fire = 1'b1; idx_d = '0; go_up = 1'b0; phase_d = PH_DOWN;
      end
      default: if (expired_i) begin
        fire = 1'b1; idx_d = idx_q + 1'b1;
      end
    endcase
    last = fire && (go_up ? (idx_d == IDX_W'(UP_STEPS - 1))
                          : (idx_d == IDX_W'(DN_STEPS - 1)));
    if (last) phase_d = go_up ? PH_ON : PH_OFF;
    act = ACT_NONE;
    if (fire) act = go_up ? up_act(idx_d) : dn_act(idx_d);
  end

  // highest bank first
  always_comb begin
    bank_sel_o = '0;
    if (int'(idx_d) >= BANK_LO && int'(idx_d) <= BANK_HI)
      bank_sel_o = SEL_W'(BANK_HI - int'(idx_d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      done_q  <= last;
    end
  end

  assign act_o  = act;
  assign load_o = fire && !last;
  assign long_o = (act == ACT_PWR_ON);
  assign busy_o = (phase_q == PH_UP) || (phase_q == PH_DOWN);
  assign done_o = done_q;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // inside a sequence the step index holds or advances by one, never restarts
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/pwr_seq_ctl_regs.sv
module pwr_seq_ctl_regs
  import pwr_seq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  act_e                 act_i,
  input  logic [SEL_W-1:0]     bank_sel_i,
  output logic                 clk_en_o,
  output logic                 hs_en_o,
  output logic                 ldo_byp_o,
  output logic                 io_clamp_o,
  output logic                 ret_en_o,
  output logic                 tag_en_o,
  output logic                 trace_en_o,
  output logic                 stby_o,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic                 core_rst_o,
  output logic                 bus_rst_o,
  output logic                 halt_o
);
  logic clk_q, hs_q, ldo_q, clamp_q, ret_q, tag_q, trace_q, stby_q;
  logic core_rst_q, bus_rst_q, halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q      <= 1'b0;
      hs_q       <= 1'b0;
      ldo_q      <= 1'b0;
      clamp_q    <= 1'b1;
      ret_q      <= 1'b0;
      tag_q      <= 1'b0;
      trace_q    <= 1'b0;
      stby_q     <= 1'b0;
      core_rst_q <= 1'b1;
      bus_rst_q  <= 1'b1;
      halt_q     <= 1'b1;
    end else begin
      case (act_i)
        ACT_HOLD_RST: begin core_rst_q <= 1'b1; bus_rst_q <= 1'b1; halt_q <= 1'b1; end
        ACT_PWR_ON:   begin hs_q <= 1'b1; ldo_q <= 1'b1; end
        ACT_MEM_BASE: begin ret_q <= 1'b1; tag_q <= 1'b1; trace_q <= 1'b1; stby_q <= 1'b1; end
        ACT_UNCLAMP:  clamp_q <= 1'b0;
        ACT_CORE_REL: core_rst_q <= 1'b0;
        ACT_CLK_ON:   clk_q <= 1'b1;
        ACT_RUN:      halt_q <= 1'b0;
        ACT_CLK_OFF:  clk_q <= 1'b0;
        ACT_CLAMP:    clamp_q <= 1'b1;
        ACT_MEM_OFF:  begin ret_q <= 1'b0; tag_q <= 1'b0; trace_q <= 1'b0; stby_q <= 1'b0; end
        ACT_RST:      begin core_rst_q <= 1'b1; bus_rst_q <= 1'b1; end
        ACT_PWR_OFF:  hs_q <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          en_q <= 1'b0;
      else if (act_i == ACT_BANK && bank_sel_i == SEL_W'(b)) en_q <= 1'b1;
      else if (act_i == ACT_MEM_OFF)                         en_q <= 1'b0;
    end
    assign bank_en_o[b] = en_q;

    if (b < NUM_BANKS - 1) begin : g_ord
      p_bank_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bank_en_o[b]) |-> bank_en_o[b+1]);
    end
  end

  assign clk_en_o   = clk_q;
  assign hs_en_o    = hs_q;
  assign ldo_byp_o  = ldo_q;
  assign io_clamp_o = clamp_q;
  assign ret_en_o   = ret_q;
  assign tag_en_o   = tag_q;
  assign trace_en_o = trace_q;
  assign stby_o     = stby_q;
  assign core_rst_o = core_rst_q;
  assign bus_rst_o  = bus_rst_q;
  assign halt_o     = halt_q;

  p_one_bank_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bank_en_o & ~$past(bank_en_o)) <= 1);

  p_mem_powered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{bank_en_o, ret_q, tag_q, trace_q, stby_q}) |-> hs_q);

  p_clk_safe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_q |-> (!clamp_q && !core_rst_q && bus_rst_q && hs_q));

  p_ldo_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(ldo_q));

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int STEP_GAP   = 4,
  parameter int SETTLE_CYC = 20,
  parameter int NUM_BANKS  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_up_i,
  input  logic                 pwr_down_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 core_clk_en_o,
  output logic                 hs_en_o,
  output logic                 ldo_byp_o,
  output logic                 io_clamp_o,
  output logic                 mem_ret_en_o,
  output logic                 l2_tag_en_o,
  output logic                 trace_mem_en_o,
  output logic                 l2_stby_o,
  output logic [NUM_BANKS-1:0] l2_bank_en_o,
  output logic                 core_rst_o,
  output logic                 bus_rst_o,
  output logic                 core_halt_o
);
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  act_e             act;
  logic [SEL_W-1:0] bank_sel;
  logic             load, long_wait, expired;

  pwr_seq_timer #(.STEP_GAP(STEP_GAP), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .long_i(long_wait), .expired_o(expired)
  );

  pwr_seq_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk_i, .rst_ni,
    .up_req_i(pwr_up_i), .down_req_i(pwr_down_i), .expired_i(expired),
    .act_o(act), .bank_sel_o(bank_sel), .load_o(load), .long_o(long_wait),
    .busy_o, .done_o
  );

  pwr_seq_ctl_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i, .rst_ni, .act_i(act), .bank_sel_i(bank_sel),
    .clk_en_o(core_clk_en_o), .hs_en_o, .ldo_byp_o, .io_clamp_o,
    .ret_en_o(mem_ret_en_o), .tag_en_o(l2_tag_en_o), .trace_en_o(trace_mem_en_o),
    .stby_o(l2_stby_o), .bank_en_o(l2_bank_en_o), .core_rst_o, .bus_rst_o,
    .halt_o(core_halt_o)
  );

endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 3;
  localparam int SETL = 7;
  localparam int NB   = 3;
  localparam int T2     = GAP + SETL;
  localparam int UP_END = T2 + (NB + 4) * GAP;
  localparam int DN_END = 4 * GAP;
  // bit order: clk hs ldo clamp ret tag trace stby bank[2:0] core_rst bus_rst halt
  localparam logic [13:0] PWR_M = 14'b01100000000000;
  localparam logic [13:0] MEM_M = 14'b00001111111000;
  localparam logic [13:0] CTL_M = 14'b10010000000111;
  localparam logic [13:0] OFF_V = 14'b00010000000111;

  logic clk = 1'b0, rst_n = 1'b0, up = 1'b0, dn = 1'b0;
  logic busy, done, clk_en, hs, ldo, clamp, ret, tag, trace, stby, crst, brst, halt;
  logic [NB-1:0] bank;
  logic [13:0] got;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit finished = 0;

  logic m_on = 0, m_busy = 0, m_down = 0, m_any = 0, m_done = 0;
  int m_t = 0, m_end = 0;
  logic [13:0] m_vec = OFF_V, m_base = OFF_V;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_top #(.STEP_GAP(GAP), .SETTLE_CYC(SETL), .NUM_BANKS(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(up), .pwr_down_i(dn),
    .busy_o(busy), .done_o(done), .core_clk_en_o(clk_en), .hs_en_o(hs),
    .ldo_byp_o(ldo), .io_clamp_o(clamp), .mem_ret_en_o(ret), .l2_tag_en_o(tag),
    .trace_mem_en_o(trace), .l2_stby_o(stby), .l2_bank_en_o(bank),
    .core_rst_o(crst), .bus_rst_o(brst), .core_halt_o(halt)
  );

  assign got = {clk_en, hs, ldo, clamp, ret, tag, trace, stby, bank, crst, brst, halt};

  function automatic logic [13:0] seq_vec(input logic go_up, input int t, input logic [13:0] base);
    logic [13:0] v;
    v = base;
    if (go_up) begin
      if (t >= 0) v[2:0] = 3'b111;
      if (t >= GAP) v[12:11] = 2'b11;
      if (t >= T2) v[9:6] = 4'b1111;
      for (int j = 0; j < NB; j++)
        if (t >= T2 + (j + 1) * GAP) v[3 + NB - 1 - j] = 1'b1;
      if (t >= T2 + (NB + 1) * GAP) v[10] = 1'b0;
      if (t >= T2 + (NB + 2) * GAP) v[2] = 1'b0;
      if (t >= T2 + (NB + 3) * GAP) v[13] = 1'b1;
      if (t >= T2 + (NB + 4) * GAP) v[0] = 1'b0;
    end else begin
      if (t >= 0) v[13] = 1'b0;
      if (t >= GAP) v[10] = 1'b1;
      if (t >= 2 * GAP) v[9:3] = '0;
      if (t >= 3 * GAP) v[2:1] = 2'b11;
      if (t >= 4 * GAP) v[12] = 1'b0;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input logic u, input logic d);
    m_done = 0;
    if (m_busy) m_t++;
    else if (!m_on && u) begin
      m_busy = 1; m_down = 0; m_t = 0; m_base = m_vec; m_end = UP_END; m_any = 1;
    end else if (m_on && d) begin
      m_busy = 1; m_down = 1; m_t = 0; m_base = m_vec; m_end = DN_END; m_any = 1;
    end
    if (m_busy) begin
      m_vec = seq_vec(!m_down, m_t, m_base);
      if (m_t == m_end) begin m_busy = 0; m_done = 1; m_on = !m_down; end
    end
  endtask

  task automatic compare();
    if (!m_any) begin
      chk("R1", "controls", 32'(got), 32'(m_vec));
      chk("R1", "busy/done", {30'd0, busy, done}, {30'd0, m_busy, m_done});
    end else begin
      if (m_down) chk("R6", "controls", 32'(got), 32'(m_vec));
      else begin
        chk("R3", "power", 32'(got & PWR_M), 32'(m_vec & PWR_M));
        chk("R4", "memory", 32'(got & MEM_M), 32'(m_vec & MEM_M));
        chk("R5", "core ctl", 32'(got & CTL_M), 32'(m_vec & CTL_M));
      end
      chk("R7", "busy/done", {30'd0, busy, done}, {30'd0, m_busy, m_done});
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic cyc(input logic u, input logic d);
    up = u; dn = d;
    @(posedge clk);
    model(u, d);
    @(negedge clk);
    up = 0; dn = 0;
    compare();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();                       // R1 reset state
    cyc(0, 1);                       // R8 shutdown while off is ignored
    chk("R8", "busy after down while off", 32'(busy), 32'd0);
    cyc(1, 0);                       // R2 start
    chk("R2", "rst/bus/halt at start", {29'd0, crst, brst, halt}, 32'd7);
    chk("R2", "hs at start", 32'(hs), 32'd0);
    cyc(0, 0);
    cyc(1, 1);                       // R8 commands while busy ignored
    chk("R8", "busy mid-sequence", 32'(busy), 32'd1);
    while (m_busy) cyc(0, 0);
    chk("R5", "bus reset after power-up", 32'(brst), 32'd1);
    cyc(1, 0);                       // R8 power-up while on is ignored
    chk("R8", "busy after up while on", 32'(busy), 32'd0);
    cyc(0, 1);
    for (int i = 0; i < GAP; i++) cyc(0, 0);
    chk("R6", "clamp after first gap", 32'(clamp), 32'd1);
    while (m_busy) cyc(0, 0);
    chk("R6", "halt untouched", 32'(halt), 32'd0);
    chk("R6", "ldo untouched", 32'(ldo), 32'd1);
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 8) == 0, ($urandom % 8) == 0);
    finish_run();
  end

endmodule